// File: doc/BRIEF.md
# Reset Sequencer with Cause Detection

This block controls how a microcontroller core leaves reset, and it records why the reset happened. After power comes up, the block waits for the oscillator to run and then lets the clock settle for a fixed number of cycles. It then waits until the shared reset pin reads high and releases the core. There are three other ways a reset can start while the core is running: a watchdog request, a clock-monitor request, or something outside pulling the pin low.

In each of those three cases the block pulls the shared open-drain pin low itself for a fixed number of E-clock periods and then lets go. A fixed number of E-clock periods after release, it reads the pin again. If the pin is still low, something outside is holding it, and the reset is recorded as external. If the pin is high, the reset is recorded as internal and keeps the cause of the request.

A pull-up that rises too slowly is therefore recorded as an external reset. The cause code is latched when the core is released. It stays fixed until the next reset.

Top module: `rstseq_top`

## Requirements
- R1: While `por_pulse` is high, and afterwards for as long as `osc_active` stays low, `core_rst` is 1 and `pin_pull_en` is 0. While `por_pulse` is high, `cause` reads 00 (power-on).
- R2: Once `osc_active` is seen high, `core_rst` stays high for STAB_CYCLES (default 4064) clock cycles. It falls within three cycles after that when the pin reads high. The pin is not driven during this delay.
- R3: If the pin reads low at the end of the stabilization delay, `core_rst` stays high and the pin is not driven until the pin reads high. The resulting cause is 00.
- R4: While the core runs, any reset condition makes `pin_pull_en` go high. It stays high for exactly DRIVE_E (default 4) cycles in which `e_stb` is high, and it falls right after the last of those.
- R5: The pin is sampled on the GAP_E-th (default 2nd) `e_stb` cycle after the drive ends. If the pin reads high at that point, the cause of the request is kept. If it reads low, the cause becomes 01, and `core_rst` holds until the pin reads high.
- R6: A watchdog request gives cause 10. A clock-monitor request gives cause 11. When both arrive in the same cycle, the clock monitor wins.
- R7: If the pin goes low from outside while the core runs, the reset sequence runs and the cause becomes 01.
- R8: Watchdog and clock-monitor requests that arrive while `core_rst` is high are ignored.
- R9: `core_rst` falls on the cycle after the pin is read high. `cause` changes only at that release and stays stable while the core runs.
- R10: `pin_level` is the raw pin. It passes through two flops before use, so a low pin while the core runs raises `pin_pull_en` on the third clock edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| por_pulse | input | 1 | Power-on pulse; synchronous reset of the sequencer |
| osc_active | input | 1 | Oscillator running |
| e_stb | input | 1 | One-cycle E-clock enable strobe |
| pin_level | input | 1 | Raw level of the open-drain reset pin |
| wd_req | input | 1 | Watchdog reset request |
| cm_req | input | 1 | Clock-monitor reset request |
| pin_pull_en | output | 1 | Enables the pull-down on the reset pin |
| core_rst | output | 1 | Reset to the core, active high |
| cause | output | 2 | Latched reset cause: 00 power-on, 01 pin, 10 watchdog, 11 clock monitor |

## Verification
Each kind of request is tried: a watchdog request alone, a clock-monitor request alone, both together, and a short external pin pulse. These patterns separate the priority between requests from the pin-based classification. An outside hold that releases after the first strobe of the gap, compared with one that releases after the second strobe, pins down exactly where the sample point lies. A power-on with the pin held low, and a request arriving during a sequence, show the hold at the end of the delay and that late requests are dropped.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_OSC, ST_STAB, ST_HOLD, ST_RUN, ST_DRIVE, ST_GAP
  } seq_state_t;

  typedef enum logic [1:0] {
    CAUSE_POR    = 2'b00,
    CAUSE_PIN    = 2'b01,
    CAUSE_WDOG   = 2'b10,
    CAUSE_CLKMON = 2'b11
  } cause_t;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rstseq_cnt.sv
module rstseq_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  assign hit = inc && (cnt_q == limit - W'(1));

  always_ff @(posedge clk) begin
    if (clr)      cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int STAB_CYCLES = 4064,
  parameter int DRIVE_E     = 4,
  parameter int GAP_E       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       osc_active,
  input  logic       e_stb,
  input  logic       pin_level,
  input  logic       wd_req,
  input  logic       cm_req,
  output logic       pin_pull_en,
  output logic       core_rst,
  output logic [1:0] cause
);
  localparam int SW   = $clog2(STAB_CYCLES + 1);
  localparam int EMAX = (DRIVE_E > GAP_E) ? DRIVE_E : GAP_E;
  localparam int EW   = $clog2(EMAX + 1);

  seq_state_t state_q, state_d;
  cause_t     pend_q, pend_d, cause_q, cause_d;
  logic       pin_s, stab_hit, e_hit, cnt_clr;
  logic [EW-1:0] e_limit;

  rstseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(por_pulse), .d(pin_level), .q(pin_s)
  );

  assign cnt_clr = por_pulse || (state_d != state_q);
  assign e_limit = (state_q == ST_DRIVE) ? EW'(DRIVE_E) : EW'(GAP_E);

  rstseq_cnt #(.W(SW)) stab_cnt_i (
    .clk(clk), .clr(cnt_clr), .inc(state_q == ST_STAB),
    .limit(SW'(STAB_CYCLES)), .hit(stab_hit)
  );

  rstseq_cnt #(.W(EW)) e_cnt_i (
    .clk(clk), .clr(cnt_clr),
    .inc(e_stb && (state_q == ST_DRIVE || state_q == ST_GAP)),
    .limit(e_limit), .hit(e_hit)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cause_d = cause_q;
    unique case (state_q)
      ST_OSC:  if (osc_active) state_d = ST_STAB;
      ST_STAB: if (stab_hit) state_d = ST_HOLD;
      ST_HOLD: if (pin_s) begin
        state_d = ST_RUN;
        cause_d = pend_q;
      end
      ST_RUN: begin
        if (cm_req) begin
          state_d = ST_DRIVE; pend_d = CAUSE_CLKMON;
        end else if (wd_req) begin
          state_d = ST_DRIVE; pend_d = CAUSE_WDOG;
        end else if (!pin_s) begin
          state_d = ST_DRIVE; pend_d = CAUSE_PIN;
        end
      end
      ST_DRIVE: if (e_hit) state_d = ST_GAP;
      ST_GAP: if (e_hit) begin
        if (pin_s) begin
          state_d = ST_RUN;
          cause_d = pend_q;
        end else begin
          state_d = ST_HOLD;
          pend_d  = CAUSE_PIN;
        end
      end
      default: state_d = ST_OSC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_pulse) begin
      state_q <= ST_OSC;
      pend_q  <= CAUSE_POR;
      cause_q <= CAUSE_POR;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cause_q <= cause_d;
    end
  end

  assign pin_pull_en = (state_q == ST_DRIVE);
  assign core_rst    = (state_q != ST_RUN);
  assign cause       = cause_q;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int DRIVE_E = 4
) (
  input logic       clk,
  input logic       por_pulse,
  input logic       e_stb,
  input logic       pin_s,
  input logic       pin_pull_en,
  input logic       core_rst,
  input logic [1:0] cause
);
  localparam int CW = $clog2(DRIVE_E + 2);
  logic [CW-1:0] drv_stb_q;

  always_ff @(posedge clk) begin
    if (por_pulse || !pin_pull_en) drv_stb_q <= '0;
    else if (e_stb)                drv_stb_q <= drv_stb_q + CW'(1);
  end

  assert_pull_in_reset_R4: assert property (@(posedge clk) disable iff (por_pulse)
    pin_pull_en |-> core_rst);

  assert_pull_from_run_R8: assert property (@(posedge clk) disable iff (por_pulse)
    $rose(pin_pull_en) |-> $past(!core_rst));

  assert_pull_end_on_strobe_R4: assert property (@(posedge clk) disable iff (por_pulse)
    $fell(pin_pull_en) |-> $past(e_stb));

  assert_drive_len_R4: assert property (@(posedge clk) disable iff (por_pulse)
    $fell(pin_pull_en) |-> (drv_stb_q == CW'(DRIVE_E)));

  assert_release_pin_high_R9: assert property (@(posedge clk) disable iff (por_pulse)
    $fell(core_rst) |-> $past(pin_s));

  assert_cause_stable_R9: assert property (@(posedge clk) disable iff (por_pulse)
    (!core_rst && $past(!core_rst)) |-> $stable(cause));
endmodule

bind rstseq_top rstseq_chk #(.DRIVE_E(DRIVE_E)) chk_i (
  .clk(clk), .por_pulse(por_pulse), .e_stb(e_stb), .pin_s(pin_s),
  .pin_pull_en(pin_pull_en), .core_rst(core_rst), .cause(cause)
);

// File: tb/rstseq_top_tb_top.sv
`timescale 1ns/1ps
module rstseq_top_tb_top;
  localparam int STAB = 4064;

  logic clk = 1'b0;
  logic por_pulse = 1'b1, osc_active = 1'b0, e_stb = 1'b0;
  logic wd_req = 1'b0, cm_req = 1'b0, ext_low = 1'b0;
  logic pin_pull_en, core_rst;
  logic [1:0] cause;
  logic pin_level;
  int checks = 0, fails = 0;
  int drv_total = 0, estb_total = 0;
  logic pull_seen = 1'b0;
  logic [1:0] div = 2'd0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign pin_level = !(pin_pull_en || ext_low);

  rstseq_top dut_i (
    .clk(clk), .por_pulse(por_pulse), .osc_active(osc_active), .e_stb(e_stb),
    .pin_level(pin_level), .wd_req(wd_req), .cm_req(cm_req),
    .pin_pull_en(pin_pull_en), .core_rst(core_rst), .cause(cause)
  );

  always @(negedge clk) begin
    div       <= div + 2'd1;
    e_stb     <= (div == 2'd3);
    pull_seen <= pin_pull_en;
  end

  always @(posedge clk) begin
    if (e_stb) estb_total <= estb_total + 1;
    if (e_stb && pull_seen) drv_total <= drv_total + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_release();
    int guard = 0;
    while (core_rst && guard < 20000) begin
      @(negedge clk); guard++;
    end
  endtask

  // {kind, hold, expected cause}; kind 0 wd, 1 cm, 2 both, 3 pin pulse
  localparam logic [5:0] VEC [8] = '{
    {2'd0, 2'd0, 2'b10}, {2'd1, 2'd0, 2'b11}, {2'd2, 2'd0, 2'b11},
    {2'd3, 2'd0, 2'b01}, {2'd0, 2'd1, 2'b10}, {2'd0, 2'd2, 2'b01},
    {2'd1, 2'd2, 2'b01}, {2'd1, 2'd1, 2'b11}
  };

  task automatic run_vec(input logic [1:0] kind, input logic [1:0] hold,
                         input logic [1:0] exp);
    int base = drv_total;
    int e_base;
    @(negedge clk);
    if (kind == 2'd3) ext_low = 1'b1;
    else begin
      wd_req = (kind != 2'd1);
      cm_req = (kind != 2'd0);
      if (hold != 2'd0) ext_low = 1'b1;
    end
    @(negedge clk);
    wd_req = 1'b0; cm_req = 1'b0;
    if (kind == 2'd3) begin
      @(negedge clk); @(negedge clk);
      ext_low = 1'b0;
    end
    if (hold != 2'd0) begin
      while (drv_total - base < 4) @(negedge clk);
      e_base = estb_total;
      while (estb_total - e_base < int'(hold)) @(negedge clk);
      ext_low = 1'b0;
    end
    wait_release();
    chk("R4 drive strobes", drv_total - base, 4);
    if (kind == 2'd3)      chk("R7 pin cause", int'(cause), int'(exp));
    else if (hold != 2'd0) chk("R5 sample point cause", int'(cause), int'(exp));
    else                   chk("R6 request cause", int'(cause), int'(exp));
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk("R1 core_rst in por", int'(core_rst), 1);
    chk("R1 pull off in por", int'(pin_pull_en), 0);
    chk("R1 cause por", int'(cause), 0);
    por_pulse = 1'b0;
    repeat (100) @(negedge clk);
    chk("R1 held without osc", int'(core_rst), 1);
    osc_active = 1'b1;
    n = 0;
    while (core_rst && n < 6000) begin
      @(negedge clk); n++;
      if (pin_pull_en) chk("R2 no drive in delay", 1, 0);
    end
    checks++;
    if (n < STAB || n > STAB + 3) begin
      fails++;
      $display("FAIL R2 delay: actual %0d expected %0d..%0d", n, STAB, STAB + 3);
    end
    chk("R2 cause after por", int'(cause), 0);
    repeat (8) @(negedge clk);

    foreach (VEC[i]) run_vec(VEC[i][5:4], VEC[i][3:2], VEC[i][1:0]);

    // R10: two-flop latency before the drive starts
    @(negedge clk); ext_low = 1'b1;
    @(negedge clk); chk("R10 no drive after 1 edge", int'(pin_pull_en), 0);
    @(negedge clk); chk("R10 no drive after 2 edges", int'(pin_pull_en), 0);
    @(negedge clk); chk("R10 drive after 3 edges", int'(pin_pull_en), 1);
    ext_low = 1'b0;
    wait_release();
    chk("R7 cause after latency test", int'(cause), 1);
    repeat (8) @(negedge clk);

    // R8: clock-monitor request during a watchdog sequence is ignored
    @(negedge clk); wd_req = 1'b1;
    @(negedge clk); wd_req = 1'b0;
    repeat (3) @(negedge clk);
    cm_req = 1'b1;
    @(negedge clk); cm_req = 1'b0;
    wait_release();
    chk("R8 late request ignored", int'(cause), 2);
    repeat (5) @(negedge clk);
    chk("R9 cause stable while running", int'(cause), 2);

    // R3: pin held low across the end of a second power-on delay
    @(negedge clk); por_pulse = 1'b1; ext_low = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cause cleared by por", int'(cause), 0);
    por_pulse = 1'b0;
    repeat (STAB + 200) @(negedge clk);
    chk("R3 held while pin low", int'(core_rst), 1);
    chk("R3 no drive while held", int'(pin_pull_en), 0);
    ext_low = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 released after pin high", int'(core_rst), 0);
    chk("R3 cause por", int'(cause), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule